// File: doc/BRIEF.md
# Two-Deep Receive Command Chaining Controller

This block sits between a host command decoder and a packet receiver. The host arms the receiver by issuing receive-enable commands, and each command names the buffer page that the next packet should land in. Two such commands may be outstanding at once. The oldest one is the active page. When a packet starts, that page's reception begins. When the packet ends, the page is retired and the next queued command becomes active, as if it had just been issued.

Each finished reception produces a sticky receive-done status with its page number, which stays until the host clears it. If a second reception finishes before the host has acknowledged the first, the second result is held back. It is loaded into the status only when the host clears the first. The interrupt line is driven from the unmasked status bits through a gap timer, so two consecutive interrupts are always separated by a guaranteed number of low cycles.

A disable command withdraws the oldest pending command, provided its reception has not begun. An enable command issued while two are already pending is dropped, and it sets a sticky overflow flag.

Top module: `rx_chain_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rx_idle`=1, `rx_busy`=0, `done_flag`=0, `ovf_flag`=0 and `irq`=0.
- R2: A `cmd_enable` pulse with page P is queued. When the queue was empty, `active_page`=P and `rx_idle`=0 on the next cycle. A second enable is held behind the first and becomes `active_page` once the first has completed (first-in first-out order).
- R3: A `pkt_start` pulse while a command is pending and no reception is running sets `rx_busy` on the next cycle. A `pkt_done` pulse while `rx_busy` is set does three things on the next cycle: it sets `done_flag`, it puts the active page on `done_page`, and it retires that command. A `pkt_done` pulse without `rx_busy` is ignored.
- R4: `done_flag` and `done_page` hold until a `cmd_clear` pulse. The pulse clears `done_flag` on the next cycle when no completion is held back.
- R5: A completion that arrives while `done_flag` is set is stored without changing `done_flag` or `done_page`. On the cycle after the next `cmd_clear`, `done_flag` is still 1 and `done_page` shows the stored page.
- R6: Between any two high periods of `irq`, the line stays low for at least `GAP_CYCLES` cycles. After a `cmd_clear` that releases a held completion, `irq` is low for exactly `GAP_CYCLES` cycles and then rises.
- R7: `irq_mask` bit 0 enables the interrupt from `done_flag`, and bit 1 enables the interrupt from `ovf_flag`. The mask changes neither `done_flag`, `ovf_flag` nor `rx_idle`.
- R8: `done_flag` is set only by a completed reception. Reset never sets it.
- R9: A `cmd_disable` pulse removes the oldest pending command if its reception has not begun. The pulse has no effect when that reception is running. Two pulses remove two pending commands.
- R10: A `cmd_enable` issued while two commands are pending is dropped and sets `ovf_flag`. `ovf_flag` stays set until `cmd_clear`.
- R11: A `pkt_start` is ignored (`rx_busy` stays 0) when no command is pending. It is also ignored when both the reported and the held completion slots are occupied.
- R12: `irq` is registered. It rises one cycle after an enabled status bit is set, unless the gap timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_enable | input | 1 | One-cycle receive-enable command |
| cmd_page | input | PAGE_W | Buffer page named by the enable command |
| cmd_clear | input | 1 | One-cycle clear-receive-interrupt command |
| cmd_disable | input | 1 | One-cycle disable-receiver command |
| pkt_start | input | 1 | Receiver strobe: a packet has begun |
| pkt_done | input | 1 | Receiver strobe: the packet has ended |
| irq_mask | input | 2 | Bit 0 enables the done interrupt, bit 1 enables the overflow interrupt |
| active_page | output | PAGE_W | Page of the oldest pending command |
| rx_idle | output | 1 | No command pending |
| rx_busy | output | 1 | A reception is running |
| done_flag | output | 1 | Chained receive-done status |
| done_page | output | PAGE_W | Page of the reported reception |
| ovf_flag | output | 1 | Sticky command overflow |
| irq | output | 1 | Host interrupt |

## Verification
Queue and status outputs (`active_page`, `rx_idle`, `rx_busy`, `done_flag`, `done_page`, `ovf_flag`) change on the first clock edge after the command or strobe. `irq` follows one edge later. After a clear, `irq` stays low for exactly `GAP_CYCLES` edges. The bench drives every pulse on a falling edge and removes it on the next falling edge. It checks status on that same falling edge, and it checks `irq` one falling edge later. The gap is measured by counting falling-edge samples until `irq` returns. Between scenarios, each test clears the status and waits longer than the gap, so that no timer state carries over.

// File: rtl/rx_chain_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the receive chaining controller.
// Assumes: mask bit positions are fixed by the host register layout.
package rx_chain_pkg;
    localparam int DEF_PAGE_W     = 2;   // default page number width
    localparam int DEF_GAP_CYCLES = 10;  // 200 ns at a 50 MHz clock
    localparam int MSK_DONE       = 0;   // irq_mask bit enabling done interrupt
    localparam int MSK_OVF        = 1;   // irq_mask bit enabling overflow interrupt
    localparam int MSK_W          = 2;
endpackage

// File: rtl/rx_cmd_queue.sv
`timescale 1ns/1ps
// Module: rx_cmd_queue
// Two-entry FIFO of receive-enable commands plus the running-reception flag.
// Slot 0 is always the oldest command. A start strobe begins slot 0. A done
// strobe retires it and reports its page. A disable retires slot 0 only when
// it has not begun. Assumes strobes and commands are single-cycle pulses.
module rx_cmd_queue #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq,
    input  logic [PAGE_W-1:0] enq_page,
    input  logic              cancel,
    input  logic              pkt_start,
    input  logic              pkt_done,
    input  logic              store_full,
    output logic [PAGE_W-1:0] head_page,
    output logic              head_valid,
    output logic              busy,
    output logic              cmp_valid,
    output logic [PAGE_W-1:0] cmp_page,
    output logic              ovf_set
);
    logic              v0_q, v1_q, busy_q;
    logic [PAGE_W-1:0] p0_q, p1_q;
    logic              v0_n, v1_n, busy_n;
    logic [PAGE_W-1:0] p0_n, p1_n;
    logic              start_ok, pop_done, pop_dis, ovf_n;

    // Next-state for slots: retire first, then append the new command.
    always_comb begin
        start_ok = pkt_start & v0_q & ~busy_q & ~store_full;
        pop_done = pkt_done & busy_q;
        pop_dis  = cancel & v0_q & ~busy_q & ~start_ok;
        v0_n = v0_q;  p0_n = p0_q;
        v1_n = v1_q;  p1_n = p1_q;
        ovf_n = 1'b0;
        if (pop_done | pop_dis) begin
            v0_n = v1_q;  p0_n = p1_q;
            v1_n = 1'b0;
        end
        if (enq) begin
            if (!v0_n) begin
                v0_n = 1'b1;  p0_n = enq_page;
            end else if (!v1_n) begin
                v1_n = 1'b1;  p1_n = enq_page;
            end else begin
                ovf_n = 1'b1;
            end
        end
        busy_n = pop_done ? 1'b0 : (busy_q | start_ok);
    end

    // State registers for both slots and the reception flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v0_q   <= 1'b0;
            v1_q   <= 1'b0;
            p0_q   <= '0;
            p1_q   <= '0;
            busy_q <= 1'b0;
        end else begin
            v0_q   <= v0_n;
            v1_q   <= v1_n;
            p0_q   <= p0_n;
            p1_q   <= p1_n;
            busy_q <= busy_n;
        end
    end

    assign head_page  = p0_q;
    assign head_valid = v0_q;
    assign busy       = busy_q;
    assign cmp_valid  = pop_done;
    assign cmp_page   = p0_q;
    assign ovf_set    = ovf_n;
endmodule

// File: rtl/rx_status_hold.sv
`timescale 1ns/1ps
// Module: rx_status_hold
// Keeps the reported completion and one held-back completion, plus the
// sticky overflow flag. A clear promotes the held completion into the
// reported slot. Assumes the producer stops starting receptions while both
// slots are full (store_full).
module rx_status_hold #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [PAGE_W-1:0] cmp_page,
    input  logic              clear,
    input  logic              ovf_set,
    output logic              done_flag,
    output logic [PAGE_W-1:0] done_page,
    output logic              ovf_flag,
    output logic              store_full
);
    logic              done_q, held_q, ovf_q;
    logic [PAGE_W-1:0] page_q, hpage_q;
    logic              done_n, held_n, ovf_n;
    logic [PAGE_W-1:0] page_n, hpage_n;

    // Next-state: apply clear (promote held), then file the new completion.
    always_comb begin
        done_n = done_q;  page_n  = page_q;
        held_n = held_q;  hpage_n = hpage_q;
        ovf_n  = ovf_q;
        if (clear) begin
            done_n = held_q;
            page_n = hpage_q;
            held_n = 1'b0;
            ovf_n  = 1'b0;
        end
        if (cmp_valid) begin
            if (!done_n) begin
                done_n = 1'b1;  page_n = cmp_page;
            end else if (!held_n) begin
                held_n = 1'b1;  hpage_n = cmp_page;
            end
        end
        if (ovf_set) begin
            ovf_n = 1'b1;
        end
    end

    // Status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            held_q  <= 1'b0;
            ovf_q   <= 1'b0;
            page_q  <= '0;
            hpage_q <= '0;
        end else begin
            done_q  <= done_n;
            held_q  <= held_n;
            ovf_q   <= ovf_n;
            page_q  <= page_n;
            hpage_q <= hpage_n;
        end
    end

    assign done_flag  = done_q;
    assign done_page  = page_q;
    assign ovf_flag   = ovf_q;
    assign store_full = done_q & held_q;
endmodule

// File: rtl/irq_gap_timer.sv
`timescale 1ns/1ps
// Module: irq_gap_timer
// Registers the raw interrupt request. Whenever the output drops, or a clear
// command arrives, the output is forced low for GAP_CYCLES cycles before it
// may follow the request again. Assumes GAP_CYCLES >= 1.
module irq_gap_timer #(
    parameter int GAP_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic restart,
    output logic irq
);
    localparam int CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(GAP_CYCLES - 1);

    logic          irq_q;
    logic [CW-1:0] cnt_q;

    // Gap counter and registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            cnt_q <= '0;
        end else if (restart || (irq_q && !irq_raw)) begin
            irq_q <= 1'b0;
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            irq_q <= irq_raw;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/rx_chain_ctrl.sv
`timescale 1ns/1ps
// Module: rx_chain_ctrl (top)
// Two-deep receive command chaining controller: command queue, completion
// status with one held-back result, and a gap-timed interrupt. Assumes all
// host commands and receiver strobes are single-cycle pulses.
module rx_chain_ctrl
    import rx_chain_pkg::*;
#(
    parameter int PAGE_W     = DEF_PAGE_W,
    parameter int GAP_CYCLES = DEF_GAP_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_enable,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              cmd_clear,
    input  logic              cmd_disable,
    input  logic              pkt_start,
    input  logic              pkt_done,
    input  logic [MSK_W-1:0]  irq_mask,
    output logic [PAGE_W-1:0] active_page,
    output logic              rx_idle,
    output logic              rx_busy,
    output logic              done_flag,
    output logic [PAGE_W-1:0] done_page,
    output logic              ovf_flag,
    output logic              irq
);
    logic              head_valid, cmp_valid, ovf_set, store_full, irq_raw;
    logic [PAGE_W-1:0] cmp_page;

    rx_cmd_queue #(.PAGE_W(PAGE_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq        (cmd_enable),
        .enq_page   (cmd_page),
        .cancel     (cmd_disable),
        .pkt_start  (pkt_start),
        .pkt_done   (pkt_done),
        .store_full (store_full),
        .head_page  (active_page),
        .head_valid (head_valid),
        .busy       (rx_busy),
        .cmp_valid  (cmp_valid),
        .cmp_page   (cmp_page),
        .ovf_set    (ovf_set)
    );

    rx_status_hold #(.PAGE_W(PAGE_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (cmp_valid),
        .cmp_page   (cmp_page),
        .clear      (cmd_clear),
        .ovf_set    (ovf_set),
        .done_flag  (done_flag),
        .done_page  (done_page),
        .ovf_flag   (ovf_flag),
        .store_full (store_full)
    );

    // Raw request: OR of status bits that are set and enabled by the mask.
    assign irq_raw = (done_flag & irq_mask[MSK_DONE]) | (ovf_flag & irq_mask[MSK_OVF]);
    assign rx_idle = ~head_valid;

    irq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_raw (irq_raw),
        .restart (cmd_clear),
        .irq     (irq)
    );
endmodule

// File: rtl/rx_chain_chk.sv
`timescale 1ns/1ps
// Module: rx_chain_chk
// Property checker bound to rx_chain_ctrl. Counts low cycles of irq to check
// the inter-interrupt gap without parameter-length delays.
module rx_chain_chk #(
    parameter int GAP_CYCLES = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pkt_start,
    input logic       pkt_done,
    input logic       cmd_clear,
    input logic [1:0] irq_mask,
    input logic       rx_idle,
    input logic       rx_busy,
    input logic       done_flag,
    input logic       ovf_flag,
    input logic       irq
);
    localparam int CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] CAP = CW'(GAP_CYCLES);

    logic [CW-1:0] low_run;

    // Saturating count of consecutive low cycles on irq.
    always_ff @(posedge clk) begin
        if (!rst_n)             low_run <= CAP;
        else if (irq)           low_run <= '0;
        else if (low_run != CAP) low_run <= low_run + 1'b1;
    end

    a_r6_irq_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (low_run >= CAP));

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !cmd_clear) |=> done_flag);

    a_r8_done_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(pkt_done));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !cmd_clear) |=> ovf_flag);

    a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((done_flag & irq_mask[0]) | (ovf_flag & irq_mask[1])));

    a_r11_idle_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_idle && pkt_start && !rx_busy) |=> !rx_busy);

    a_r3_busy_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> !rx_idle);
endmodule

bind rx_chain_ctrl rx_chain_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .pkt_done  (pkt_done),
    .cmd_clear (cmd_clear),
    .irq_mask  (irq_mask),
    .rx_idle   (rx_idle),
    .rx_busy   (rx_busy),
    .done_flag (done_flag),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
);

// File: tb/sim_rx_chain_ctrl.sv
`timescale 1ns/1ps
// Directed bench for rx_chain_ctrl: inputs change on falling edges, outputs
// are sampled on falling edges.
module sim_rx_chain_ctrl;
    localparam int PW  = 2;
    localparam int GAP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_enable = 1'b0, cmd_clear = 1'b0, cmd_disable = 1'b0;
    logic [PW-1:0] cmd_page = '0;
    logic          pkt_start = 1'b0, pkt_done = 1'b0;
    logic [1:0]    irq_mask = 2'b11;
    logic [PW-1:0] active_page, done_page;
    logic          rx_idle, rx_busy, done_flag, ovf_flag, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rx_chain_ctrl #(.PAGE_W(PW), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_page(cmd_page),
        .cmd_clear(cmd_clear), .cmd_disable(cmd_disable), .pkt_start(pkt_start),
        .pkt_done(pkt_done), .irq_mask(irq_mask), .active_page(active_page),
        .rx_idle(rx_idle), .rx_busy(rx_busy), .done_flag(done_flag),
        .done_page(done_page), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_enable(input logic [PW-1:0] p);
        cmd_enable = 1'b1; cmd_page = p; @(negedge clk); cmd_enable = 1'b0;
    endtask
    task automatic do_clear;
        cmd_clear = 1'b1; @(negedge clk); cmd_clear = 1'b0;
    endtask
    task automatic do_disable;
        cmd_disable = 1'b1; @(negedge clk); cmd_disable = 1'b0;
    endtask
    task automatic do_start;
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
    endtask
    task automatic do_done;
        pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
    endtask
    task automatic settle;
        do_clear(); wait_cyc(GAP + 2);
    endtask

    // R1, R8: state during and just after reset.
    task automatic t_reset;
        rst_n = 1'b0; wait_cyc(3);
        check("R1 idle in reset", rx_idle, 1);
        check("R8 done clear in reset", done_flag, 0);
        rst_n = 1'b1; @(negedge clk);
        check("R1 idle", rx_idle, 1);
        check("R1 busy", rx_busy, 0);
        check("R8 done after reset", done_flag, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 irq", irq, 0);
    endtask

    // R2, R3, R4, R12: one complete reception.
    task automatic t_single;
        do_enable(2);
        check("R2 active page", active_page, 2);
        check("R2 not idle", rx_idle, 0);
        do_start();
        check("R3 busy", rx_busy, 1);
        do_done();
        check("R3 done flag", done_flag, 1);
        check("R3 done page", done_page, 2);
        check("R3 busy cleared", rx_busy, 0);
        check("R3 command retired", rx_idle, 1);
        check("R12 irq not yet", irq, 0);
        @(negedge clk);
        check("R12 irq one cycle later", irq, 1);
        do_done();
        check("R3 stray done ignored page", done_page, 2);
        wait_cyc(3);
        check("R4 done sticky", done_flag, 1);
        do_clear();
        check("R4 done cleared", done_flag, 0);
        check("R4 irq cleared", irq, 0);
        wait_cyc(GAP + 2);
    endtask

    // R2, R5, R6: two chained receptions, second held back.
    task automatic t_chain;
        int n;
        do_enable(1);
        do_enable(3);
        check("R2 oldest active", active_page, 1);
        do_start(); do_done();
        check("R5 first page", done_page, 1);
        check("R2 second becomes active", active_page, 3);
        check("R2 second pending", rx_idle, 0);
        do_start(); do_done();
        check("R5 first page kept", done_page, 1);
        check("R5 done kept", done_flag, 1);
        check("R6 irq high before clear", irq, 1);
        do_clear();
        check("R5 done after clear", done_flag, 1);
        check("R5 held page shown", done_page, 3);
        n = 0;
        while (irq == 1'b0 && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R6 gap length", n, GAP);
        do_clear();
        check("R4 done cleared after second", done_flag, 0);
        wait_cyc(GAP + 2);
    endtask

    // R7: mask gates interrupt only.
    task automatic t_mask;
        irq_mask = 2'b10;
        do_enable(0); do_start(); do_done();
        check("R7 done set while masked", done_flag, 1);
        check("R7 idle unaffected", rx_idle, 1);
        wait_cyc(2);
        check("R7 irq masked", irq, 0);
        irq_mask = 2'b11;
        @(negedge clk);
        check("R7 irq after unmask", irq, 1);
        settle();
    endtask

    // R9: disable cancels oldest unless begun.
    task automatic t_disable;
        do_enable(1); do_enable(2);
        do_disable();
        check("R9 oldest removed", active_page, 2);
        check("R9 one left", rx_idle, 0);
        do_disable();
        check("R9 both removed", rx_idle, 1);
        do_enable(3); do_start();
        do_disable();
        check("R9 running kept busy", rx_busy, 1);
        check("R9 running kept page", active_page, 3);
        do_done();
        check("R9 running completes", done_page, 3);
        check("R9 done flag", done_flag, 1);
        settle();
    endtask

    // R10: overflow on third enable.
    task automatic t_overflow;
        do_enable(0); do_enable(1);
        check("R10 no ovf at two", ovf_flag, 0);
        do_enable(2);
        check("R10 ovf set", ovf_flag, 1);
        @(negedge clk);
        check("R10 ovf irq", irq, 1);
        do_disable(); do_disable();
        check("R10 third dropped", rx_idle, 1);
        check("R10 ovf sticky", ovf_flag, 1);
        do_clear();
        check("R10 ovf cleared", ovf_flag, 0);
        wait_cyc(GAP + 2);
    endtask

    // R11, R8: start ignored with nothing pending or with full store.
    task automatic t_ignore;
        do_start();
        check("R11 start without pending", rx_busy, 0);
        do_done();
        check("R8 done without reception", done_flag, 0);
        do_enable(0); do_start(); do_done();
        do_enable(1); do_start(); do_done();
        do_enable(2);
        do_start();
        check("R11 start blocked when full", rx_busy, 0);
        check("R11 command still pending", rx_idle, 0);
        do_clear();
        check("R5 promote page", done_page, 1);
        do_start();
        check("R11 start after slot frees", rx_busy, 1);
        do_done();
        check("R5 reported kept", done_page, 1);
        do_clear();
        check("R5 third promoted", done_page, 2);
        do_clear();
        check("R4 all cleared", done_flag, 0);
        wait_cyc(GAP + 2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_mask();
        t_disable();
        t_overflow();
        t_ignore();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule